// File: doc/BRIEF.md
# SPI Master Controller with Byte FIFOs

This block is a register-mapped serial master that moves 8-bit words over a four-wire SPI link. Software queues outgoing bytes in a 16-entry transmit FIFO and collects incoming bytes from a 16-entry receive FIFO. The serial clock has a fixed half period of `HALF_DIV` system clocks, chosen at build time. The controller supports all four clock polarity and phase combinations and shifts the most significant bit first.

A transmit-hold control bit keeps the shifter idle while software loads the queue, so a batch of bytes can go out back to back. A small interrupt unit flags two events: the transmit queue has drained completely, and a received byte was lost. Each event has a per-source enable, and a global enable gates the output. Slave selects are active low. They are either generated automatically around each byte or driven by software directly. A keyed write to a reset register returns the whole controller to its reset state.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, `ss_n` is all ones, `sclk`, `mosi` and `irq` are 0, the control register reads 0, and the status register reads 0x05. Status bits: bit0 receive-empty, bit1 receive-full, bit2 transmit-empty, bit3 transmit-full, bit4 receive-overrun.
- R2: Each word is 8 bits, MSB first, and uses 16 `sclk` edges. With phase bit 0, `miso` is sampled on the leading edge of each pair and `mosi` changes on the trailing edge. With phase bit 1 this is reversed. The first `mosi` bit is presented before the first edge (phase 0) or on it (phase 1).
- R3: While the hold bit (control bit7) is set, no `sclk` edge occurs even if the transmit FIFO holds data. Clearing the bit starts shifting the queued bytes. Shifting also needs enable (bit0) and master (bit1) set.
- R4: Writes to the TX data port (0x08) are queued. When 16 bytes are queued, transmit-full is set and further writes are dropped.
- R5: Every completed word is pushed into the receive FIFO. When the receive FIFO is full, the new word is dropped, status bit4 is set and stays set, and interrupt status bit1 is set. Reads of the RX data port (0x0C) return the oldest word.
- R6: In automatic mode (control bit6 = 0), `ss_n` equals the select register (0x10) while a word is shifting and between back-to-back words, and is all ones when idle. In manual mode (bit6 = 1), `ss_n` follows the select register at all times, including while held.
- R7: Interrupt status bit0 (0x20) is set only when a word completes with the transmit FIFO empty. Interrupt status bits clear when a 1 is written to them. `irq` is high only when a status bit, its enable bit (0x24) and the global enable (0x28 bit0) are all set.
- R8: Writing control bit4 empties the transmit FIFO, and writing bit5 empties the receive FIFO and clears the overrun flag. Both bits read back as 0 afterwards.
- R9: Writing 0x0A to offset 0x40 resets the whole controller, including the FIFOs, the control, select and enable registers, and the interrupt state. Any other value written there has no effect.
- R10: Control bit2 sets the idle level of `sclk`, and `sclk` returns to that level after each word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on the next cycle |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus strobes are single-cycle and never target two registers at once. They also assume that software writes the select register with at most one bit low. The bench keeps to these rules by driving the strobes only from its write and read tasks, and by always writing one-hot-low select values. A bench slave model follows `sclk` edges. It checks `mosi` and `ss_n` at the sampling edge of each mode and returns known reply bytes on `miso`, so every phase and polarity combination is swept with expected data computed from byte indices.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int unsigned ADDR_W = 7;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 7'h04;
  localparam logic [ADDR_W-1:0] OFS_TXD   = 7'h08;
  localparam logic [ADDR_W-1:0] OFS_RXD   = 7'h0C;
  localparam logic [ADDR_W-1:0] OFS_SSEL  = 7'h10;
  localparam logic [ADDR_W-1:0] OFS_ISTAT = 7'h20;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 7'h24;
  localparam logic [ADDR_W-1:0] OFS_GIE   = 7'h28;
  localparam logic [ADDR_W-1:0] OFS_SRST  = 7'h40;
  localparam logic [7:0]        SRST_KEY  = 8'h0A;

  // control register, MSB first: bit7 hold ... bit0 enable
  typedef struct packed {
    logic hold;
    logic man_ss;
    logic rx_flush;
    logic tx_flush;
    logic cpha;
    logic cpol;
    logic master;
    logic en;
  } ctrl_t;

  typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;
endpackage

// File: rtl/sfm_fifo.sv
module sfm_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == DEPTH_C);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= DEPTH_C);
  a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> full);
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);
endmodule

// File: rtl/sfm_shifter.sv
module sfm_shifter import sfm_pkg::*; #(
  parameter int unsigned W        = 8,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] din,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         miso,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte,
  output logic         sclk,
  output logic         mosi
);
  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned EW = $clog2(2 * W);
  localparam logic [DW-1:0] DIV_LAST  = DW'(HALF_DIV - 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(2 * W - 1);

  sh_state_e     state;
  logic [DW-1:0] div;
  logic [EW-1:0] ecnt;
  logic [W-1:0]  tx_sh, rx_sh;
  logic          cpha_l, lead;

  assign busy = (state == SH_RUN);
  assign lead = ~ecnt[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SH_IDLE;
      div     <= '0;
      ecnt    <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      cpha_l  <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SH_IDLE: begin
          sclk <= cpol;
          if (start) begin
            state  <= SH_RUN;
            cpha_l <= cpha;
            div    <= '0;
            ecnt   <= '0;
            tx_sh  <= cpha ? din : (din << 1);
            if (!cpha) mosi <= din[W-1];
          end
        end
        default: begin
          if (div == DIV_LAST) begin
            div  <= '0;
            sclk <= ~sclk;
            ecnt <= ecnt + 1'b1;
            if (lead ^ cpha_l) begin
              rx_sh <= {rx_sh[W-2:0], miso};
            end else begin
              mosi  <= tx_sh[W-1];
              tx_sh <= tx_sh << 1;
            end
            if (ecnt == EDGE_LAST) begin
              state   <= SH_IDLE;
              done    <= 1'b1;
              rx_byte <= cpha_l ? {rx_sh[W-2:0], miso} : rx_sh;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
      endcase
    end
  end

  a_r10_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $past(!rst)) |-> (sclk == $past(cpol)));
  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master import sfm_pkg::*; #(
  parameter int unsigned NUM_SS     = 4,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned HALF_DIV   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [6:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n,
  output logic              irq
);
  localparam int unsigned WORD = 8;

  logic              srst_q, core_rst;
  ctrl_t             ctrl;
  logic [NUM_SS-1:0] ssel, ss_n_q;
  logic [1:0]        istat, ien, istat_set, istat_clr;
  logic              gie, ovr, irq_q;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              busy, done, start, tx_push, rx_pop;
  logic [WORD-1:0]   tx_head, rx_head, rx_byte;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign core_rst     = rst | srst_q;

  assign tx_push = reg_wr && (reg_addr == OFS_TXD);
  assign rx_pop  = reg_rd && (reg_addr == OFS_RXD) && !rx_empty;
  assign start   = ctrl.en && ctrl.master && !ctrl.hold && !ctrl.tx_flush
                   && !tx_empty && !busy;

  assign istat_set = {done && rx_full, done && tx_empty};
  assign istat_clr = (reg_wr && reg_addr == OFS_ISTAT) ? reg_wdata[1:0] : 2'b00;

  sfm_fifo #(.W(WORD), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst(core_rst), .clr(ctrl.tx_flush),
    .push(tx_push), .din(reg_wdata[WORD-1:0]), .pop(start),
    .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  sfm_fifo #(.W(WORD), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst(core_rst), .clr(ctrl.rx_flush),
    .push(done), .din(rx_byte), .pop(rx_pop),
    .dout(rx_head), .empty(rx_empty), .full(rx_full)
  );

  sfm_shifter #(.W(WORD), .HALF_DIV(HALF_DIV)) shifter_i (
    .clk(clk), .rst(core_rst), .start(start), .din(tx_head),
    .cpol(ctrl.cpol), .cpha(ctrl.cpha), .miso(miso),
    .busy(busy), .done(done), .rx_byte(rx_byte),
    .sclk(sclk), .mosi(mosi)
  );

  // keyed soft reset, one cycle pulse
  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else     srst_q <= reg_wr && (reg_addr == OFS_SRST) && (reg_wdata[7:0] == SRST_KEY);
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      ctrl <= '0;
      ssel <= '1;
      ien  <= '0;
      gie  <= 1'b0;
    end else begin
      ctrl.tx_flush <= 1'b0;
      ctrl.rx_flush <= 1'b0;
      if (reg_wr && reg_addr == OFS_CTRL) ctrl <= ctrl_t'(reg_wdata[7:0]);
      if (reg_wr && reg_addr == OFS_SSEL) ssel <= reg_wdata[NUM_SS-1:0];
      if (reg_wr && reg_addr == OFS_IEN)  ien  <= reg_wdata[1:0];
      if (reg_wr && reg_addr == OFS_GIE)  gie  <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      istat  <= '0;
      ovr    <= 1'b0;
      irq_q  <= 1'b0;
      ss_n_q <= '1;
    end else begin
      istat <= (istat & ~istat_clr) | istat_set;
      if (ctrl.rx_flush)  ovr <= 1'b0;
      else if (done && rx_full) ovr <= 1'b1;
      irq_q  <= gie && |(istat & ien);
      ss_n_q <= (ctrl.man_ss || busy || start) ? ssel : '1;
    end
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL:  reg_rdata <= 32'(ctrl);
        OFS_STAT:  reg_rdata <= 32'({ovr, tx_full, tx_empty, rx_full, rx_empty});
        OFS_RXD:   reg_rdata <= 32'(rx_head);
        OFS_SSEL:  reg_rdata <= 32'(ssel);
        OFS_ISTAT: reg_rdata <= 32'(istat);
        OFS_IEN:   reg_rdata <= 32'(ien);
        OFS_GIE:   reg_rdata <= 32'(gie);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign ss_n = ss_n_q;
  assign irq  = irq_q;

  a_r3_inhibit_holds: assert property (@(posedge clk) disable iff (core_rst)
    (ctrl.hold && !busy) |=> !busy);
  a_r6_select_follows: assert property (@(posedge clk) disable iff (core_rst)
    ($past(busy) && !$past(core_rst)) |-> (ss_n == $past(ssel)));
  a_r7_no_irq_without_status: assert property (@(posedge clk) disable iff (core_rst)
    ($past(istat == 2'b00) && !$past(core_rst)) |-> !irq);
  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (core_rst)
    (ovr && !ctrl.rx_flush) |=> ovr);
  a_r9_srst_clears: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (ctrl == '0 && ssel == '1 && istat == '0));
endmodule

// File: tb/spi_fifo_master_tb_top.sv
module spi_fifo_master_tb_top;
  localparam int NSS = 4;
  localparam logic [31:0] C_EN = 1, C_MST = 2, C_CPOL = 4, C_CPHA = 8,
                          C_TXR = 16, C_RXR = 32, C_MAN = 64, C_HOLD = 128;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, mosi, miso = 1'b0, irq;
  logic [NSS-1:0] ss_n;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_fifo_master #(.NUM_SS(NSS), .FIFO_DEPTH(16), .HALF_DIV(2)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ss_n(ss_n), .irq(irq)
  );

  function automatic logic [7:0] reply(int i);
    return 8'(i * 37 + 5);
  endfunction
  function automatic logic [7:0] tx_val(int m, int i);
    return 8'(m * 53 + i * 29 + 17);
  endfunction

  // bench slave model
  logic mon_clr = 1'b0, cpha_b = 1'b0, prev_sclk = 1'b0;
  logic [NSS-1:0] exp_ss = '1;
  logic [7:0] mon_sh = '0, rb;
  logic [7:0] mon_bytes [0:31];
  int e = 0, sk = 0, byte_ct = 0, ss_bad = 0;

  always @(negedge clk) begin
    if (mon_clr) begin
      e = 0; sk = 0; byte_ct = 0; ss_bad = 0;
      prev_sclk = sclk;
      rb = reply(0);
      miso = cpha_b ? 1'b0 : rb[7];
    end else if (sclk !== prev_sclk) begin
      if (ss_n !== exp_ss) ss_bad++;
      rb = reply(byte_ct);
      if (((e % 2) == 0) ^ cpha_b) mon_sh = {mon_sh[6:0], mosi};
      else begin
        if (cpha_b) miso = rb[7 - sk];
        else if (sk < 7) miso = rb[6 - sk];
        sk++;
      end
      e++;
      if (e == 16) begin
        if (byte_ct < 32) mon_bytes[byte_ct] = mon_sh;
        byte_ct++;
        e = 0; sk = 0;
        rb = reply(byte_ct);
        if (!cpha_b) miso = rb[7];
      end
      prev_sclk = sclk;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic mon_clear();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic wait_tx_done();
    logic [31:0] v;
    for (int k = 0; k < 1000; k++) begin
      rd(7'h20, v);
      if (v[0]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] cw;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ss_n", 32'(ss_n), 32'hF);
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 mosi", 32'(mosi), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(7'h04, v); chk("R1 status", v, 32'h05);
    rd(7'h00, v); chk("R1 ctrl", v, 32'h00);

    // R2/R10/R6: sweep all four modes
    for (int m = 0; m < 4; m++) begin
      cw = C_EN | C_MST | (m[1] ? C_CPOL : 0) | (m[0] ? C_CPHA : 0);
      wr(7'h00, cw | C_HOLD);
      wr(7'h10, 32'hD);
      exp_ss = 4'hD;
      cpha_b = m[0];
      repeat (3) @(posedge clk);
      chk("R10 idle level", 32'(sclk), 32'(m[1]));
      mon_clear();
      for (int i = 0; i < 3; i++) wr(7'h08, 32'(tx_val(m, i)));
      wr(7'h20, 3);
      wr(7'h00, cw);
      wait_tx_done();
      for (int i = 0; i < 3; i++) begin
        chk("R2 mosi byte", 32'(mon_bytes[i]), 32'(tx_val(m, i)));
        rd(7'h0C, v); chk("R2 miso byte", v, 32'(reply(i)));
      end
      chk("R2 edge count", 32'(byte_ct * 16 + e), 48);
      chk("R10 sclk returns idle", 32'(sclk), 32'(m[1]));
      chk("R6 auto select during shift", 32'(ss_bad), 0);
      chk("R6 auto select idle", 32'(ss_n), 32'hF);
    end

    // R3 hold bit
    cpha_b = 1'b0;
    wr(7'h00, C_EN | C_MST | C_HOLD);
    repeat (4) @(posedge clk);
    mon_clear();
    wr(7'h08, 32'hA5);
    wr(7'h20, 3);
    repeat (100) @(posedge clk);
    chk("R3 no edges while held", 32'(byte_ct * 16 + e), 0);
    rd(7'h04, v); chk("R3 byte still queued", v, 32'h01);
    rd(7'h20, v); chk("R3 no tx-empty while held", v, 0);
    wr(7'h00, C_EN | C_MST);
    wait_tx_done();
    chk("R3 byte sent after release", 32'(mon_bytes[0]), 32'hA5);
    rd(7'h0C, v); chk("R5 rx after release", v, 32'(reply(0)));

    // R7 tx-empty only after full drain
    mon_clear();
    wr(7'h00, C_EN | C_MST | C_HOLD);
    wr(7'h08, 32'h3C); wr(7'h08, 32'hC3);
    wr(7'h20, 3);
    wr(7'h00, C_EN | C_MST);
    for (int k = 0; k < 500 && byte_ct < 1; k++) @(negedge clk);
    rd(7'h20, v); chk("R7 no flag with bytes queued", v, 0);
    wait_tx_done();
    rd(7'h20, v); chk("R7 flag after drain", v, 1);
    rd(7'h0C, v); rd(7'h0C, v);

    // R7 gating and W1C
    wr(7'h24, 1); wr(7'h28, 0);
    repeat (3) @(posedge clk);
    chk("R7 irq gated by global enable", 32'(irq), 0);
    wr(7'h28, 1);
    repeat (2) @(posedge clk);
    chk("R7 irq asserted", 32'(irq), 1);
    wr(7'h20, 1);
    repeat (2) @(posedge clk);
    chk("R7 irq after clear", 32'(irq), 0);
    rd(7'h20, v); chk("R7 status cleared by one", v, 0);
    wr(7'h24, 0);

    // R4 full, R8 tx flush
    wr(7'h00, C_EN | C_MST | C_HOLD);
    for (int i = 0; i < 17; i++) wr(7'h08, 32'(i));
    rd(7'h04, v); chk("R4 tx full", v, 32'h09);
    wr(7'h00, C_EN | C_MST | C_HOLD | C_TXR);
    repeat (2) @(posedge clk);
    rd(7'h04, v); chk("R8 tx flushed", v, 32'h05);
    rd(7'h00, v); chk("R8 flush bit self-clears", v, 32'h83);

    // R5 overrun
    mon_clear();
    wr(7'h20, 3);
    for (int i = 0; i < 16; i++) wr(7'h08, 32'(tx_val(7, i)));
    wr(7'h00, C_EN | C_MST);
    wait_tx_done();
    wr(7'h20, 3);
    wr(7'h08, 32'h77);
    wait_tx_done();
    chk("R5 extra byte still sent", 32'(mon_bytes[16]), 32'h77);
    rd(7'h04, v); chk("R5 full with overrun", v, 32'h16);
    rd(7'h20, v); chk("R5 overrun interrupt", v, 32'h3);
    for (int i = 0; i < 16; i++) begin
      rd(7'h0C, v); chk("R5 rx order", v, 32'(reply(i)));
    end
    rd(7'h04, v); chk("R5 overrun sticky", v, 32'h15);
    wr(7'h00, C_EN | C_MST | C_RXR);
    repeat (2) @(posedge clk);
    rd(7'h04, v); chk("R8 rx flush clears overrun", v, 32'h05);

    // R6 manual select
    wr(7'h00, C_EN | C_MST | C_MAN | C_HOLD);
    wr(7'h10, 32'hB);
    repeat (3) @(posedge clk);
    chk("R6 manual idle", 32'(ss_n), 32'hB);
    exp_ss = 4'hB;
    mon_clear();
    wr(7'h20, 3);
    wr(7'h08, 32'h5A); wr(7'h08, 32'h96);
    repeat (50) @(posedge clk);
    chk("R6 manual while held", 32'(ss_n), 32'hB);
    wr(7'h00, C_EN | C_MST | C_MAN);
    wait_tx_done();
    chk("R6 manual during shift", 32'(ss_bad), 0);
    chk("R6 manual after", 32'(ss_n), 32'hB);
    rd(7'h0C, v); rd(7'h0C, v);
    wr(7'h10, 32'hF);
    repeat (2) @(posedge clk);
    chk("R6 manual deselect", 32'(ss_n), 32'hF);

    // R9 soft reset
    wr(7'h00, C_EN | C_MST | C_HOLD);
    wr(7'h40, 32'h0B);
    repeat (3) @(posedge clk);
    rd(7'h00, v); chk("R9 wrong key ignored", v, 32'h83);
    wr(7'h10, 32'h7);
    wr(7'h24, 3);
    wr(7'h40, 32'h0A);
    repeat (3) @(posedge clk);
    rd(7'h00, v); chk("R9 ctrl reset", v, 0);
    rd(7'h10, v); chk("R9 select reset", v, 32'hF);
    rd(7'h24, v); chk("R9 enable reset", v, 0);
    rd(7'h04, v); chk("R9 status reset", v, 32'h05);
    chk("R9 ss_n reset", 32'(ss_n), 32'hF);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule